// File: doc/BRIEF.md
# Repetition-Interval Sequence Timing Controller

This block runs the timing of one repetition interval on a scanner module. The host first loads a small table of sequence elements, one per slot. Each slot holds a start sample, a length in samples and a type: transmit pulse, receive window, gradient waveform, or end marker. The host then arms the controller. A rising edge on the external master sync input starts the interval. From that edge the controller counts sample-clock enables from zero. It walks the table in slot order, comparing the running sample number against the current element's window.

While an element is in its window, the controller gives one strobe per sample on the DMA request line that belongs to that element's type. Transmit and receive elements also raise a gating level, which can drive power amplifiers and T/R switches. When the controller reaches an end marker, or runs past the last slot, it returns to idle and waits for the next sync.

Streamed operation depends on arming. Each interval must be armed before its sync edge, and starting an interval consumes the arm. A sync that arrives unarmed does not start anything; it only latches a stopped flag. A sync that arrives during a running interval is counted as an overrun and is otherwise ignored. Commands can pause the count at any time or halt the interval.

Top module: `tr_sequencer`

## Requirements
- R1: A rising edge on `msync` while idle and armed raises `busy` within three clock cycles and clears `armed`. An interval never starts without a prior arm.
- R2: Sample numbering starts at 0 with the first accepted sample enable after `busy` rises. An element with start S and length L issues its strobes on samples S through S+L-1.
- R3: Type codes are 00 transmit (`dma_tx`), 01 receive (`dma_rx`), 10 gradient (`dma_grad`) and 11 end marker. In-window samples give exactly one strobe, and at most one strobe line is high in any cycle.
- R4: `gate_tx` or `gate_rx` is high while a transmit or receive element is in its window, and is high in every cycle that carries that element's strobe. Gradient elements raise no gate, and the two gates are never high together.
- R5: The interval ends, and `busy` falls, at an end-marker slot or after all 8 slots have been used.
- R6: A sync edge while idle and unarmed sets `stopped`, starts nothing and issues no strobes. An `arm` pulse sets `armed` and clears `stopped`.
- R7: A sync edge during a running interval increments `overrun_cnt`, which saturates. The sample count and the element walk continue undisturbed.
- R8: While `pause` is high, sample enables are not counted and no strobes are issued. After release, the interval resumes at the sample where it stopped.
- R9: A `halt` pulse ends a running interval at the next clock edge and clears `armed`. No further strobes follow.
- R10: An element of length 0 issues no strobe and is skipped.
- R11: After reset, `busy`, `armed`, `stopped`, both gates, all strobes and `overrun_cnt` are 0. Every table slot holds the end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msync | input | 1 | External master sync; a rising edge starts an interval |
| smp_en | input | 1 | Sample clock enable, one cycle per sample |
| arm | input | 1 | Host pulse: mark the next interval as loaded |
| pause | input | 1 | Level: freeze the sample count |
| halt | input | 1 | Pulse: abort the running interval |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 3 | Table slot to write |
| tbl_start | input | 20 | Element start sample |
| tbl_len | input | 16 | Element length in samples |
| tbl_kind | input | 2 | Element type code |
| busy | output | 1 | Interval running |
| armed | output | 1 | Next interval loaded |
| stopped | output | 1 | Sync arrived while unarmed |
| overrun_cnt | output | 8 | Count of syncs received during a running interval |
| dma_tx | output | 1 | Transmit DMA request strobe |
| dma_rx | output | 1 | Receive DMA request strobe |
| dma_grad | output | 1 | Gradient DMA request strobe |
| gate_tx | output | 1 | Transmit gating level |
| gate_rx | output | 1 | Receive gating level |

## Verification
A corrupted sample counter or slot index shows up at the strobe ports at the next accepted sample. The strobes then fall on the wrong sample numbers, come in the wrong count, or appear on another type's line. The bench compares the first and last strobe positions of each element against the table it wrote. A wrong arm or run flag shows on `busy`, `stopped` or `armed` within three cycles of the sync edge. A restart on an overrun sync shifts every later strobe position, so it is caught as soon as the element ends. A gate that lags or leads its element shows in the first in-window cycle as a strobe without its gate.

// File: rtl/tr_sequencer.sv
module tr_sequencer #(
  parameter int N_EL  = 8,
  parameter int SW    = 20,
  parameter int LW    = 16,
  parameter int OVR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     msync,
  input  logic                     smp_en,
  input  logic                     arm,
  input  logic                     pause,
  input  logic                     halt,
  input  logic                     tbl_we,
  input  logic [$clog2(N_EL)-1:0]  tbl_addr,
  input  logic [SW-1:0]            tbl_start,
  input  logic [LW-1:0]            tbl_len,
  input  logic [1:0]               tbl_kind,
  output logic                     busy,
  output logic                     armed,
  output logic                     stopped,
  output logic [OVR_W-1:0]         overrun_cnt,
  output logic                     dma_tx,
  output logic                     dma_rx,
  output logic                     dma_grad,
  output logic                     gate_tx,
  output logic                     gate_rx
);
  localparam int AW = $clog2(N_EL);
  localparam int IW = AW + 1;
  localparam int EW = SW + 1;
  localparam logic [1:0] K_TX = 2'b00, K_RX = 2'b01, K_GR = 2'b10, K_END = 2'b11;

  logic [SW-1:0] t_start [N_EL];
  logic [LW-1:0] t_len   [N_EL];
  logic [1:0]    t_kind  [N_EL];

  logic [2:0]    ms_q;
  logic          running;
  logic [EW-1:0] cnt;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_EL; i++) begin
        t_start[i] <= '0;
        t_len[i]   <= '0;
        t_kind[i]  <= K_END;
      end
    end else if (tbl_we) begin
      t_start[tbl_addr] <= tbl_start;
      t_len[tbl_addr]   <= tbl_len;
      t_kind[tbl_addr]  <= tbl_kind;
    end
  end

  wire           sync_edge = ms_q[1] & ~ms_q[2];
  wire           idx_ok    = idx < IW'(N_EL);
  wire [AW-1:0]  sel       = idx[AW-1:0];
  wire [1:0]     cur_kind  = t_kind[sel];
  wire [EW-1:0]  e_start   = {1'b0, t_start[sel]};
  wire [EW-1:0]  e_end     = e_start + EW'(t_len[sel]);
  wire           at_end    = !idx_ok || cur_kind == K_END;
  wire           in_win    = running && !at_end && cnt >= e_start && cnt < e_end;
  wire           go        = running && smp_en && !pause;
  wire           hit       = go && in_win;
  wire           passed    = running && !at_end && cnt >= e_end;
  wire           adv       = passed || (hit && cnt == e_end - EW'(1));

  assign busy     = running;
  assign dma_tx   = hit && cur_kind == K_TX;
  assign dma_rx   = hit && cur_kind == K_RX;
  assign dma_grad = hit && cur_kind == K_GR;
  assign gate_tx  = in_win && cur_kind == K_TX;
  assign gate_rx  = in_win && cur_kind == K_RX;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q        <= '0;
      running     <= 1'b0;
      cnt         <= '0;
      idx         <= '0;
      armed       <= 1'b0;
      stopped     <= 1'b0;
      overrun_cnt <= '0;
    end else begin
      ms_q <= {ms_q[1:0], msync};
      if (running && !halt) begin
        if (at_end) begin
          running <= 1'b0;
        end else begin
          if (go)  cnt <= cnt + EW'(1);
          if (adv) idx <= idx + IW'(1);
        end
      end
      if (sync_edge && !halt) begin
        if (running) begin
          if (overrun_cnt != '1) overrun_cnt <= overrun_cnt + OVR_W'(1);
        end else if (armed) begin
          running <= 1'b1;
          cnt     <= '0;
          idx     <= '0;
          armed   <= 1'b0;
        end else begin
          stopped <= 1'b1;
        end
      end
      if (halt) begin
        running <= 1'b0;
        armed   <= 1'b0;
      end
      if (arm) begin
        armed   <= 1'b1;
        stopped <= 1'b0;
      end
    end
  end

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_tx, dma_rx, dma_grad}));

  // R3
  strobe_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_tx || dma_rx || dma_grad) && !halt |=> cnt == $past(cnt) + EW'(1));

  // R4
  gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_tx && gate_rx));

  // R1
  start_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(armed));

  // R1
  arm_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) && !$past(arm) |-> !armed);

  // R6
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> !$past(running));

  // R7
  overrun_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_cnt != $past(overrun_cnt) |-> $past(running));

  // R8
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pause) && $past(running) && running |-> $stable(cnt));
endmodule

// File: tb/tr_sequencer_bench.sv
module tr_sequencer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msync = 0, smp_en = 0, arm = 0, pause = 0, halt = 0;
  logic tbl_we = 0;
  logic [2:0] tbl_addr = '0;
  logic [19:0] tbl_start = '0;
  logic [15:0] tbl_len = '0;
  logic [1:0] tbl_kind = '0;
  logic busy, armed, stopped, dma_tx, dma_rx, dma_grad, gate_tx, gate_rx;
  logic [7:0] overrun_cnt;

  tr_sequencer u_tr_sequencer (
    .clk(clk), .rst_n(rst_n), .msync(msync), .smp_en(smp_en), .arm(arm),
    .pause(pause), .halt(halt), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_start(tbl_start), .tbl_len(tbl_len), .tbl_kind(tbl_kind),
    .busy(busy), .armed(armed), .stopped(stopped), .overrun_cnt(overrun_cnt),
    .dma_tx(dma_tx), .dma_rx(dma_rx), .dma_grad(dma_grad),
    .gate_tx(gate_tx), .gate_rx(gate_rx));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic smp_run = 0;
  int div = 0;

  initial forever begin
    @(posedge clk); #1;
    div = (div + 1) % 4;
    smp_en = smp_run && div == 0;
  end

  int scnt, n_tx, n_rx, n_gr, f_tx, l_tx, f_rx, l_rx, f_gr, l_gr, viol, pstrb, gtx_seen;
  logic prev_busy = 0;

  task automatic clr_stats();
    n_tx = 0; n_rx = 0; n_gr = 0; f_tx = -1; l_tx = -1; f_rx = -1; l_rx = -1;
    f_gr = -1; l_gr = -1; viol = 0; pstrb = 0; gtx_seen = 0;
  endtask

  always @(negedge clk) begin
    if (busy && !prev_busy) scnt = 0;
    prev_busy = busy;
    if ((dma_tx && !gate_tx) || (dma_rx && !gate_rx) || (gate_tx && gate_rx)) viol++;
    if (dma_grad && (gate_tx || gate_rx)) viol++;
    if ((gate_tx || gate_rx) && !busy) viol++;
    if (gate_tx) gtx_seen++;
    if (pause && (dma_tx || dma_rx || dma_grad)) pstrb++;
    if (dma_tx) begin if (f_tx < 0) f_tx = scnt; l_tx = scnt; n_tx++; end
    if (dma_rx) begin if (f_rx < 0) f_rx = scnt; l_rx = scnt; n_rx++; end
    if (dma_grad) begin if (f_gr < 0) f_gr = scnt; l_gr = scnt; n_gr++; end
    if (busy && smp_en && !pause) scnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int s, input int l, input int k);
    @(posedge clk); #1;
    tbl_we = 1; tbl_addr = 3'(a); tbl_start = 20'(s); tbl_len = 16'(l); tbl_kind = 2'(k);
    @(posedge clk); #1;
    tbl_we = 0;
  endtask

  task automatic pulse_arm();
    @(posedge clk); #1; arm = 1; @(posedge clk); #1; arm = 0;
  endtask

  task automatic pulse_sync();
    @(posedge clk); #1; msync = 1; cyc(3); msync = 0; cyc(3);
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    chk(!busy, tag, int'(busy), 0);
    cyc(2);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !armed && !stopped, "R11 flags", int'({busy, armed, stopped}), 0);
    chk(!gate_tx && !gate_rx && !dma_tx && !dma_rx && !dma_grad, "R11 outputs", 1, 0);
    chk(overrun_cnt == 0, "R11 overrun", overrun_cnt, 0);
    // R11 every slot end marker: an armed sync ends at once with no strobes
    clr_stats(); smp_run = 1; pulse_arm(); pulse_sync(); wait_idle("R11 empty table");
    chk(n_tx + n_rx + n_gr == 0, "R11 empty strobes", n_tx + n_rx + n_gr, 0);
    smp_run = 0;
  endtask

  task automatic t_basic();
    wr(0, 2, 3, 0); wr(1, 10, 4, 1); wr(2, 0, 0, 3);
    clr_stats(); smp_run = 1;
    pulse_arm();
    chk(armed, "R6 arm sets armed", int'(armed), 1);
    @(posedge clk); #1; msync = 1;
    cyc(3);
    @(negedge clk);
    chk(busy, "R1 busy after sync", int'(busy), 1);
    chk(!armed, "R1 arm consumed", int'(armed), 0);
    msync = 0;
    wait_idle("R5 end marker idle");
    chk(n_tx == 3 && f_tx == 2 && l_tx == 4, "R2 tx window", f_tx * 100 + l_tx, 204);
    chk(n_rx == 4 && f_rx == 10 && l_rx == 13, "R2 rx window", f_rx * 100 + l_rx, 1013);
    chk(n_gr == 0, "R3 no gradient strobe", n_gr, 0);
    chk(viol == 0 && gtx_seen > 0, "R4 gating", viol, 0);
    smp_run = 0;
  endtask

  task automatic t_noarm();
    clr_stats(); smp_run = 1;
    pulse_sync(); cyc(10);
    chk(stopped && !busy, "R6 unarmed sync stops", int'({stopped, busy}), 2);
    chk(n_tx + n_rx + n_gr == 0, "R6 no strobes", n_tx + n_rx + n_gr, 0);
    pulse_arm(); @(negedge clk);
    chk(!stopped && armed, "R6 arm clears stopped", int'({stopped, armed}), 1);
    smp_run = 0;
  endtask

  task automatic t_zero();
    wr(0, 3, 0, 0); wr(1, 5, 2, 1); wr(2, 0, 0, 3);
    clr_stats(); smp_run = 1;
    pulse_sync(); wait_idle("R10 idle");
    chk(n_tx == 0, "R10 zero-length silent", n_tx, 0);
    chk(n_rx == 2 && f_rx == 5 && l_rx == 6, "R10 next element", f_rx * 100 + l_rx, 506);
    smp_run = 0;
  endtask

  task automatic t_overrun();
    int t = 0;
    wr(0, 0, 20, 2); wr(1, 0, 0, 3);
    clr_stats(); smp_run = 1;
    pulse_arm(); pulse_sync();
    while (n_gr < 5 && t < 1000) begin @(negedge clk); t++; end
    pulse_sync();
    chk(busy, "R7 still busy", int'(busy), 1);
    wait_idle("R7 idle");
    chk(overrun_cnt == 1, "R7 overrun count", overrun_cnt, 1);
    chk(n_gr == 20 && f_gr == 0 && l_gr == 19, "R7 no restart", n_gr, 20);
    chk(viol == 0, "R4 gradient ungated", viol, 0);
    smp_run = 0;
  endtask

  task automatic t_pause();
    int t = 0, held;
    wr(0, 4, 8, 0); wr(1, 0, 0, 3);
    clr_stats(); smp_run = 1;
    pulse_arm(); pulse_sync();
    while (n_tx < 3 && t < 1000) begin @(negedge clk); t++; end
    @(posedge clk); #1; pause = 1;
    cyc(2); held = n_tx; cyc(40);
    chk(n_tx == held && busy, "R8 frozen", n_tx, held);
    pause = 0;
    wait_idle("R8 idle");
    chk(n_tx == 8 && f_tx == 4 && l_tx == 11, "R8 resumed", l_tx, 11);
    chk(pstrb == 0, "R8 no strobe in pause", pstrb, 0);
    smp_run = 0;
  endtask

  task automatic t_halt();
    int t = 0, held;
    wr(0, 0, 50, 0); wr(1, 0, 0, 3);
    clr_stats(); smp_run = 1;
    pulse_arm(); pulse_arm(); pulse_sync();
    pulse_arm();
    while (n_tx < 5 && t < 1000) begin @(negedge clk); t++; end
    @(posedge clk); #1; halt = 1; @(posedge clk); #1; halt = 0;
    @(negedge clk);
    chk(!busy && !armed, "R9 halted", int'({busy, armed}), 0);
    held = n_tx; cyc(30);
    chk(n_tx == held && n_tx < 50, "R9 no more strobes", n_tx, held);
    smp_run = 0;
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) wr(i, i * 3, 2, 2);
    clr_stats(); smp_run = 1;
    pulse_arm(); pulse_sync(); wait_idle("R5 past last slot");
    chk(n_gr == 16 && f_gr == 0 && l_gr == 22, "R5 all slots", n_gr * 100 + l_gr, 1622);
    smp_run = 0;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clr_stats();
    cyc(3); rst_n = 1; cyc(2);
    t_reset();
    t_basic();
    t_noarm();
    t_zero();
    t_overrun();
    t_pause();
    t_halt();
    t_full();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule